// File: doc/BRIEF.md
# Predicate Shadow Resolution Unit

This unit is the function unit that owns predication for vector instructions in a scoreboard-scheduled out-of-order core. A predicated vector instruction issues into it with a mask of the element slots that were allocated as placeholder operations and a flag that selects zeroing. Each allocated slot then comes under a write-block shadow. The element operation may compute its result, but it may not write that result to the register file.

The predicate lives in the same integer register file as the operands. The instruction just ahead may therefore still be producing it. The unit waits in a busy state until the scoreboard reports the predicate register ready and supplies its value. It samples that value once and resolves every allocated slot by the bit at the same index:

- A set bit releases the shadow so the result can commit.
- A clear bit kills the element.
- A clear bit with zeroing selected turns the element into a zero-result write instead of killing it.

All resolutions come out together as one-cycle pulses, and the unit is then free for the next instruction.

Top module: `pred_shadow_unit`

## Requirements
- R1: While reset is applied, and after it is released, `busy`, `shadow_active` and all resolution pulses are zero. `issue_ready` is 0 while reset is applied and becomes 1 no later than the second rising clock edge after `rst_n` rises.
- R2: On a clock edge where `issue_valid` and `issue_ready` are both 1, the issue is accepted. From the next cycle `busy` is 1, `issue_ready` is 0, and `shadow_active` equals the captured `issue_mask` (bit i is slot i).
- R3: An `issue_valid` presented while `busy` is 1 is ignored. The shadows, the captured mask and the captured zeroing mode all stay as they were at acceptance.
- R4: While `busy` is 1 and `pred_ready` is 0, `busy` stays 1, `shadow_active` holds its value, and no kill, zero or release pulse is produced.
- R5: Resolution pulses appear only in the cycle after an edge where `busy` and `pred_ready` were both 1, and they last exactly one cycle.
- R6: At resolution, each allocated slot whose `pred_data` bit is 1 gets an `elem_release` pulse at the same index.
- R7: At resolution with zeroing off, each allocated slot whose `pred_data` bit is 0 gets an `elem_kill` pulse and no other pulse.
- R8: At resolution with zeroing on, each allocated slot whose `pred_data` bit is 0 gets an `elem_zero` pulse and no `elem_kill` pulse.
- R9: Slots not set in the captured mask never receive a kill, zero or release pulse. For each slot, at most one of the three pulses is high in any cycle.
- R10: In the resolution cycle `shadow_active` is all zero, `busy` is 0 and `issue_ready` is 1, so a new issue can be accepted in that same cycle.
- R11: A `pred_ready` that is high in the issue cycle, while `busy` is still 0, is not honoured. The predicate only counts from the cycle after acceptance.
- R12: The zeroing mode is taken from `issue_zeroing` at acceptance. Later changes on that input do not affect the resolution.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_valid | input | 1 | A predicated vector instruction requests issue |
| issue_mask | input | NUM_ELEM | Placeholder slots allocated by this instruction |
| issue_zeroing | input | 1 | Zeroing mode for the instruction |
| issue_ready | output | 1 | The unit can accept an issue this cycle |
| pred_ready | input | 1 | The predicate register has been written and is readable |
| pred_data | input | NUM_ELEM | Predicate value, one bit per element |
| busy | output | 1 | An instruction is held awaiting its predicate |
| shadow_active | output | NUM_ELEM | Write-block shadow per slot |
| elem_kill | output | NUM_ELEM | One-cycle kill pulse per slot |
| elem_zero | output | NUM_ELEM | One-cycle zero-result pulse per slot |
| elem_release | output | NUM_ELEM | One-cycle shadow-release pulse per slot |

## Verification
A slot shadow that is wrongly set or cleared shows at the ports in the very next cycle as a mismatch of `shadow_active` against the issued mask. It shows again at resolution as a pulse on a slot that was never allocated, or a missing pulse on one that was. A wrong captured zeroing mode only appears at resolution, where kill and zero pulses trade places. A state machine that resolves too early or too late shows as pulses one cycle off the predicate-ready edge, or as `busy` staying high. The directed scenarios therefore check the shadows on every held cycle and the exact pulse cycle on every resolution.

// File: rtl/psu_pkg.sv
package psu_pkg;

  typedef enum logic {
    PSU_IDLE = 1'b0,
    PSU_WAIT = 1'b1
  } psu_state_e;

endpackage

// File: rtl/psu_rst_sync.sv
module psu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int TOP = STAGES - 1;

  logic [TOP:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[TOP-1:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[TOP];

endmodule

// File: rtl/psu_ctrl.sv
module psu_ctrl
  import psu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic issue_valid,
  input  logic issue_zeroing,
  input  logic pred_ready,
  output logic issue_ready,
  output logic issue_fire,
  output logic resolve_fire,
  output logic busy,
  output logic zero_mode
);

  psu_state_e state_q, state_d;
  logic       zmode_q, zmode_d;
  logic       zmode_en;

  // Issue and predicate are never combined: issue is only taken in IDLE,
  // the predicate only in WAIT.
  always_comb begin
    issue_ready  = (state_q == PSU_IDLE) && rst_n;
    issue_fire   = issue_ready && issue_valid;
    resolve_fire = (state_q == PSU_WAIT) && pred_ready;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PSU_IDLE: if (issue_fire)   state_d = PSU_WAIT;
      PSU_WAIT: if (resolve_fire) state_d = PSU_IDLE;
      default:                    state_d = PSU_IDLE;
    endcase
  end

  always_comb begin
    zmode_en = issue_fire;
    zmode_d  = issue_zeroing;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PSU_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zmode_q <= 1'b0;
    end else if (zmode_en) begin
      zmode_q <= zmode_d;
    end
  end

  assign busy      = (state_q == PSU_WAIT);
  assign zero_mode = zmode_q;

endmodule

// File: rtl/psu_slot.sv
module psu_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic alloc_en,
  input  logic alloc_bit,
  input  logic resolve_en,
  input  logic pred_bit,
  input  logic zero_mode,
  output logic shadow,
  output logic kill_pulse,
  output logic zero_pulse,
  output logic release_pulse
);

  logic shadow_q, shadow_d, shadow_en;
  logic kill_q, kill_d;
  logic zero_q, zero_d;
  logic rel_q, rel_d;
  logic resolving;

  always_comb begin
    resolving = resolve_en && shadow_q;
    shadow_en = alloc_en || resolve_en;
    shadow_d  = alloc_en ? alloc_bit : 1'b0;
    rel_d     = resolving && pred_bit;
    kill_d    = resolving && !pred_bit && !zero_mode;
    zero_d    = resolving && !pred_bit && zero_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= 1'b0;
    end else if (shadow_en) begin
      shadow_q <= shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kill_q <= 1'b0;
      zero_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      kill_q <= kill_d;
      zero_q <= zero_d;
      rel_q  <= rel_d;
    end
  end

  assign shadow        = shadow_q;
  assign kill_pulse    = kill_q;
  assign zero_pulse    = zero_q;
  assign release_pulse = rel_q;

endmodule

// File: rtl/pred_shadow_unit.sv
module pred_shadow_unit #(
  parameter int NUM_ELEM   = 8,
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_valid,
  input  logic [NUM_ELEM-1:0] issue_mask,
  input  logic                issue_zeroing,
  output logic                issue_ready,
  input  logic                pred_ready,
  input  logic [NUM_ELEM-1:0] pred_data,
  output logic                busy,
  output logic [NUM_ELEM-1:0] shadow_active,
  output logic [NUM_ELEM-1:0] elem_kill,
  output logic [NUM_ELEM-1:0] elem_zero,
  output logic [NUM_ELEM-1:0] elem_release
);

  logic rst_int_n;
  logic issue_fire;
  logic resolve_fire;
  logic zero_mode;

  psu_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  psu_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .issue_valid   (issue_valid),
    .issue_zeroing (issue_zeroing),
    .pred_ready    (pred_ready),
    .issue_ready   (issue_ready),
    .issue_fire    (issue_fire),
    .resolve_fire  (resolve_fire),
    .busy          (busy),
    .zero_mode     (zero_mode)
  );

  for (genvar i = 0; i < NUM_ELEM; i++) begin : g_slot
    psu_slot u_slot (
      .clk           (clk),
      .rst_n         (rst_int_n),
      .alloc_en      (issue_fire),
      .alloc_bit     (issue_mask[i]),
      .resolve_en    (resolve_fire),
      .pred_bit      (pred_data[i]),
      .zero_mode     (zero_mode),
      .shadow        (shadow_active[i]),
      .kill_pulse    (elem_kill[i]),
      .zero_pulse    (elem_zero[i]),
      .release_pulse (elem_release[i])
    );
  end

endmodule

// File: rtl/psu_checker.sv
module psu_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         issue_valid,
  input logic         issue_ready,
  input logic [N-1:0] issue_mask,
  input logic         pred_ready,
  input logic [N-1:0] pred_data,
  input logic         busy,
  input logic [N-1:0] shadow_active,
  input logic [N-1:0] elem_kill,
  input logic [N-1:0] elem_zero,
  input logic [N-1:0] elem_release
);

  logic [N-1:0] any_pulse;
  assign any_pulse = elem_kill | elem_zero | elem_release;

  assert_idle_no_shadow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (shadow_active == '0));

  assert_issue_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_ready) |=> (busy && !issue_ready && shadow_active == $past(issue_mask)));

  assert_hold_while_waiting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pred_ready) |=> (busy && $stable(shadow_active) && any_pulse == '0));

  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|any_pulse) |-> $past(busy && pred_ready));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|any_pulse) |=> (any_pulse == '0));

  assert_release_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pred_ready) |=> (elem_release == $past(shadow_active & pred_data)));

  assert_only_allocated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (any_pulse & ~$past(shadow_active)) == '0);

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((elem_kill & elem_zero) | (elem_kill & elem_release) | (elem_zero & elem_release)) == '0);

  assert_resolve_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && pred_ready) |=> (!busy && issue_ready && shadow_active == '0));

endmodule

bind pred_shadow_unit psu_checker #(.N(NUM_ELEM)) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .issue_valid   (issue_valid),
  .issue_ready   (issue_ready),
  .issue_mask    (issue_mask),
  .pred_ready    (pred_ready),
  .pred_data     (pred_data),
  .busy          (busy),
  .shadow_active (shadow_active),
  .elem_kill     (elem_kill),
  .elem_zero     (elem_zero),
  .elem_release  (elem_release)
);

// File: tb/pred_shadow_unit_tb.sv
module pred_shadow_unit_tb;

  localparam int N = 8;

  logic         clk;
  logic         rst_n;
  logic         issue_valid;
  logic [N-1:0] issue_mask;
  logic         issue_zeroing;
  logic         issue_ready;
  logic         pred_ready;
  logic [N-1:0] pred_data;
  logic         busy;
  logic [N-1:0] shadow_active;
  logic [N-1:0] elem_kill;
  logic [N-1:0] elem_zero;
  logic [N-1:0] elem_release;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  pred_shadow_unit #(.NUM_ELEM(N)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .issue_valid   (issue_valid),
    .issue_mask    (issue_mask),
    .issue_zeroing (issue_zeroing),
    .issue_ready   (issue_ready),
    .pred_ready    (pred_ready),
    .pred_data     (pred_data),
    .busy          (busy),
    .shadow_active (shadow_active),
    .elem_kill     (elem_kill),
    .elem_zero     (elem_zero),
    .elem_release  (elem_release)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  // Accept an issue; optionally hold pred_ready high in the same cycle.
  task automatic do_issue(input logic [N-1:0] m, input logic z, input logic pr_same);
    @(negedge clk);
    issue_valid   = 1'b1;
    issue_mask    = m;
    issue_zeroing = z;
    pred_ready    = pr_same;
    pred_data     = '0;
    tick();
    chk("R2 busy", 32'(busy), 32'd1);
    chk("R2 ready", 32'(issue_ready), 32'd0);
    chk("R2 shadow", 32'(shadow_active), 32'(m));
    @(negedge clk);
    issue_valid = 1'b0;
    pred_ready  = 1'b0;
  endtask

  // Present the predicate and check the resolution cycle and the one after.
  task automatic do_resolve(input logic [N-1:0] m, input logic z, input logic [N-1:0] p);
    logic [N-1:0] exp_k, exp_z, exp_r;
    exp_r = m & p;
    exp_k = z ? '0 : (m & ~p);
    exp_z = z ? (m & ~p) : '0;
    @(negedge clk);
    pred_ready = 1'b1;
    pred_data  = p;
    tick();
    chk("R6 release", 32'(elem_release), 32'(exp_r));
    chk("R7 kill", 32'(elem_kill), 32'(exp_k));
    chk("R8 zero", 32'(elem_zero), 32'(exp_z));
    chk("R10 shadow clear", 32'(shadow_active), 32'd0);
    chk("R10 idle", 32'({busy, issue_ready}), 32'b01);
    @(negedge clk);
    pred_ready = 1'b0;
    tick();
    chk("R5 single pulse", 32'({elem_kill, elem_zero, elem_release}), 32'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    issue_valid = 1'b0; issue_mask = '0; issue_zeroing = 1'b0;
    pred_ready = 1'b0; pred_data = '0;
    repeat (3) tick();
    chk("R1 reset state", 32'({busy, issue_ready, shadow_active, elem_kill, elem_zero, elem_release}), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) tick();
    chk("R1 ready after release", 32'(issue_ready), 32'd1);
    chk("R1 busy after release", 32'(busy), 32'd0);
  endtask

  task automatic t_release_and_kill;
    do_issue(8'hFF, 1'b0, 1'b0);
    do_resolve(8'hFF, 1'b0, 8'hA5);
  endtask

  task automatic t_zeroing;
    do_issue(8'hFF, 1'b1, 1'b0);
    do_resolve(8'hFF, 1'b1, 8'h3C);
  endtask

  task automatic t_partial_mask;
    do_issue(8'h5A, 1'b0, 1'b0);
    do_resolve(8'h5A, 1'b0, 8'h0F);   // R9: slots outside 0x5A stay quiet
  endtask

  task automatic t_hold;
    do_issue(8'h81, 1'b1, 1'b0);
    for (int c = 0; c < 5; c++) begin
      tick();
      chk("R4 busy held", 32'(busy), 32'd1);
      chk("R4 shadow held", 32'(shadow_active), 32'h81);
      chk("R4 no pulse", 32'({elem_kill, elem_zero, elem_release}), 32'd0);
    end
    do_resolve(8'h81, 1'b1, 8'h01);
  endtask

  task automatic t_busy_reissue;
    do_issue(8'h0F, 1'b0, 1'b0);
    @(negedge clk);
    issue_valid = 1'b1; issue_mask = 8'hF0; issue_zeroing = 1'b1;
    tick();
    chk("R3 shadow unchanged", 32'(shadow_active), 32'h0F);
    @(negedge clk);
    issue_valid = 1'b0;
    tick();
    // R12: zeroing input still 1, captured mode was 0 -> kills expected
    do_resolve(8'h0F, 1'b0, 8'h00);
  endtask

  task automatic t_same_cycle_pred;
    do_issue(8'h3C, 1'b0, 1'b1);      // R11 pred_ready with issue
    chk("R11 no pulse", 32'({elem_kill, elem_zero, elem_release}), 32'd0);
    tick();
    chk("R11 still busy", 32'(busy), 32'd1);
    chk("R11 shadow kept", 32'(shadow_active), 32'h3C);
    do_resolve(8'h3C, 1'b0, 8'hFF);
  endtask

  task automatic t_back_to_back;
    do_issue(8'h11, 1'b0, 1'b0);
    @(negedge clk);
    pred_ready = 1'b1; pred_data = 8'h10;
    tick();
    chk("R10 ready in resolve cycle", 32'(issue_ready), 32'd1);
    @(negedge clk);
    pred_ready = 1'b0;
    issue_valid = 1'b1; issue_mask = 8'hC0; issue_zeroing = 1'b1;
    tick();
    chk("R10 reissue accepted", 32'({busy, shadow_active}), 32'h1C0);
    @(negedge clk);
    issue_valid = 1'b0;
    do_resolve(8'hC0, 1'b1, 8'h40);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_release_and_kill();
    t_zeroing();
    t_partial_mask();
    t_hold();
    t_busy_reissue();
    t_same_cycle_pred();
    t_back_to_back();
    repeat (2) tick();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=complete");
    finish_run();
  end

endmodule